// File: doc/BRIEF.md
# SIMD Saturating Pixel Pack Unit

This unit narrows fixed-point SIMD lanes into smaller saturated values in a single registered stage. A 5-bit scale moves each lane's binary point left before a fixed right shift drops its fraction; the result is then clamped to the output type. Three formats are offered: four signed halfword lanes to four unsigned bytes, two signed word lanes to unsigned bytes merged into a shifted copy of a base operand, and two signed word lanes to two signed 16-bit fixed-point values.

Each format has its own scale width, binary-point position and clamp range. The merge format lets a caller build up packed pixels over several operations: each call pushes the base operand's bytes up one place inside each 32-bit word and drops the new byte into the freed lowest byte. Intermediate values are formed wide enough that no scale can overflow before the clamp.

Top module: `simd_pack_sat`

## Requirements
- R1: In the cycle after `rst` is high, `result` is 0 and `out_valid` is 0.
- R2: `out_valid` is high in exactly the cycle after an accepted `in_valid`; `result` changes only in that cycle and otherwise holds its value.
- R3: Mode 2'b00: for lane i (0..3) taken from `pack_src[63-16*i -: 16]` as signed, the value (lane << scale[3:0]) >>> 7 is clamped to 0..255 and written to `result[31-8*i -: 8]`; `result[63:32]` is 0.
- R4: Mode 2'b00 ignores `scale[4]`: two scales that differ only in that bit give the same result.
- R5: Mode 2'b01: for lane i (0..1) taken from `pack_src[63-32*i -: 32]` as signed, the value (lane << scale) >>> 23 is clamped to 0..255.
- R6: Mode 2'b01: 32-bit word i of `result` (bits [63-32*i -: 32]) equals word i of `merge_base` shifted left by 8, with the lane-i byte of R5 in its lowest byte (byte 3 and byte 7 counted from the most significant).
- R7: Mode 2'b10: for lane i (0..1) taken as in R5, (lane << scale) >>> 16 is saturated to -32768..32767 and written in two's complement to `result[31-16*i -: 16]`; `result[63:32]` is 0.
- R8: At every scale up to 31 the shifted value is exact before clamping, so large positive lanes reach the top clamp and negative lanes the bottom clamp, never wrapping.
- R9: Mode 2'b11 produces a `result` of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands present this cycle |
| mode | input | 2 | Pack format select |
| scale | input | 5 | Left shift applied to each lane |
| pack_src | input | 64 | Lanes to be packed |
| merge_base | input | 64 | Base operand for the merge format |
| out_valid | output | 1 | Result registered from last cycle's operands |
| result | output | 64 | Packed result |

## Verification
Within one operation, some lanes can saturate while neighbours pass through, and in the merge format the shift of the base operand and the insertion of the new byte fall in the same output word. Tests place a negative lane, an overflowing lane and an in-range lane side by side, and chain merge operations by feeding each result back as the next base; each output is compared lane by lane against a bench model built from the shift and clamp rules, so a byte landing in the wrong place or a clamp leaking into a neighbour shows up.

// File: rtl/pk_pkg.sv
package pk_pkg;

    localparam int PK_DATA_W  = 64;
    localparam int PK_SCALE_W = 5;
    localparam int PK_HALF_W  = 16;
    localparam int PK_WORD_W  = 32;
    localparam int PK_FRAC_H  = 7;   // binary point, halfword-to-byte
    localparam int PK_FRAC_WB = 23;  // binary point, word-to-byte
    localparam int PK_FRAC_WF = 16;  // binary point, word-to-fixed

    typedef enum logic [1:0] {
        PK_H_TO_U8   = 2'b00,
        PK_W_MERGE   = 2'b01,
        PK_W_TO_FIX  = 2'b10,
        PK_RESERVED  = 2'b11
    } pk_mode_e;

    typedef struct packed {
        logic [7:0]  u8;
        logic [15:0] fx;
    } pk_word_res_t;

    function automatic logic [7:0] pk_clamp_u8(input logic neg, input logic big,
                                                input logic [7:0] low);
        if (neg)      return 8'h00;
        else if (big) return 8'hFF;
        else          return low;
    endfunction

endpackage

// File: rtl/pk_lane_half.sv
module pk_lane_half
    import pk_pkg::*;
#(
    parameter int IN_W = PK_HALF_W,
    parameter int SH_W = PK_SCALE_W - 1,
    parameter int FRAC = PK_FRAC_H
) (
    input  logic [IN_W-1:0] lane,
    input  logic [SH_W-1:0] shamt,
    output logic [7:0]      packed_byte
);
    localparam int WIDE = IN_W + (1 << SH_W) - 1;

    logic signed [WIDE-1:0] ext;
    logic signed [WIDE-1:0] scaled;
    logic signed [WIDE-1:0] shr;

    always_comb begin
        ext         = {{(WIDE-IN_W){lane[IN_W-1]}}, lane};
        scaled      = ext <<< shamt;
        shr         = scaled >>> FRAC;
        packed_byte = pk_clamp_u8(shr[WIDE-1], |shr[WIDE-2:8], shr[7:0]);
    end
endmodule

// File: rtl/pk_lane_word.sv
module pk_lane_word
    import pk_pkg::*;
#(
    parameter int IN_W   = PK_WORD_W,
    parameter int SH_W   = PK_SCALE_W,
    parameter int FRAC_B = PK_FRAC_WB,
    parameter int FRAC_F = PK_FRAC_WF
) (
    input  logic [IN_W-1:0] lane,
    input  logic [SH_W-1:0] shamt,
    output pk_word_res_t    res
);
    localparam int WIDE = IN_W + (1 << SH_W) - 1;

    logic signed [WIDE-1:0] ext;
    logic signed [WIDE-1:0] scaled;
    logic signed [WIDE-1:0] shb;
    logic signed [WIDE-1:0] shf;
    logic                   fneg;

    always_comb begin
        ext    = {{(WIDE-IN_W){lane[IN_W-1]}}, lane};
        scaled = ext <<< shamt;
        shb    = scaled >>> FRAC_B;
        shf    = scaled >>> FRAC_F;
        res.u8 = pk_clamp_u8(shb[WIDE-1], |shb[WIDE-2:8], shb[7:0]);
        fneg   = shf[WIDE-1];
        if (fneg && !(&shf[WIDE-2:15]))
            res.fx = 16'h8000;
        else if (!fneg && (|shf[WIDE-2:15]))
            res.fx = 16'h7FFF;
        else
            res.fx = shf[15:0];
    end
endmodule

// File: rtl/simd_pack_sat.sv
module simd_pack_sat
    import pk_pkg::*;
#(
    parameter int DATA_W  = PK_DATA_W,
    parameter int SCALE_W = PK_SCALE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        mode,
    input  logic [SCALE_W-1:0] scale,
    input  logic [DATA_W-1:0] pack_src,
    input  logic [DATA_W-1:0] merge_base,
    output logic              out_valid,
    output logic [DATA_W-1:0] result
);
    localparam int N_H  = DATA_W / PK_HALF_W;
    localparam int N_W  = DATA_W / PK_WORD_W;
    localparam int HALF = DATA_W / 2;

    logic [7:0]    hbyte [N_H];
    pk_word_res_t  wres  [N_W];
    logic [DATA_W-1:0] nxt;

    for (genvar h = 0; h < N_H; h++) begin : g_half
        pk_lane_half u_lane (
            .lane        (pack_src[DATA_W-1-PK_HALF_W*h -: PK_HALF_W]),
            .shamt       (scale[SCALE_W-2:0]),
            .packed_byte (hbyte[h])
        );
    end

    for (genvar w = 0; w < N_W; w++) begin : g_word
        pk_lane_word u_lane (
            .lane  (pack_src[DATA_W-1-PK_WORD_W*w -: PK_WORD_W]),
            .shamt (scale),
            .res   (wres[w])
        );
    end

    always_comb begin
        nxt = '0;
        unique case (pk_mode_e'(mode))
            PK_H_TO_U8: begin
                for (int h = 0; h < N_H; h++)
                    nxt[HALF-1-8*h -: 8] = hbyte[h];
            end
            PK_W_MERGE: begin
                for (int w = 0; w < N_W; w++)
                    nxt[DATA_W-1-PK_WORD_W*w -: PK_WORD_W] =
                        {merge_base[DATA_W-1-PK_WORD_W*w-8 -: PK_WORD_W-8], wres[w].u8};
            end
            PK_W_TO_FIX: begin
                for (int w = 0; w < N_W; w++)
                    nxt[HALF-1-16*w -: 16] = wres[w].fx;
            end
            default: nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                result <= nxt;
        end
    end
endmodule

// File: rtl/pk_sva.sv
module pk_sva (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [1:0]  mode,
    input logic [63:0] merge_base,
    input logic        out_valid,
    input logic [63:0] result
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (result == 64'd0 && !out_valid));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result) && !out_valid));

    // R3
    half_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 2'b00) |=> result[63:32] == 32'd0);

    // R6
    merge_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 2'b01) |=>
            (result[63:40] == $past(merge_base[55:32]) && result[31:8] == $past(merge_base[23:0])));

    // R7
    fix_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 2'b10) |=> result[63:32] == 32'd0);

    // R9
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 2'b11) |=> result == 64'd0);
endmodule

bind simd_pack_sat pk_sva u_pk_sva (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .mode       (mode),
    .merge_base (merge_base),
    .out_valid  (out_valid),
    .result     (result)
);

// File: tb/tb_simd_pack_sat.sv
module tb_simd_pack_sat;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  mode;
    logic [4:0]  scale;
    logic [63:0] pack_src;
    logic [63:0] merge_base;
    logic        out_valid;
    logic [63:0] result;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    simd_pack_sat dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .scale(scale),
        .pack_src(pack_src), .merge_base(merge_base),
        .out_valid(out_valid), .result(result)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] clamp8(input longint v);
        if (v < 0) return 8'h00;
        if (v > 255) return 8'hFF;
        return v[7:0];
    endfunction

    function automatic logic [63:0] model(input logic [1:0] m, input logic [4:0] sc,
                                          input logic [63:0] src, input logic [63:0] base);
        logic [63:0] r = '0;
        longint v;
        case (m)
            2'b00: for (int i = 0; i < 4; i++) begin
                v = longint'($signed(src[63-16*i -: 16]));
                v = (v <<< sc[3:0]) >>> 7;
                r[31-8*i -: 8] = clamp8(v);
            end
            2'b01: for (int i = 0; i < 2; i++) begin
                v = longint'($signed(src[63-32*i -: 32]));
                v = (v <<< sc) >>> 23;
                r[63-32*i -: 32] = {base[55-32*i -: 24], clamp8(v)};
            end
            2'b10: for (int i = 0; i < 2; i++) begin
                v = longint'($signed(src[63-32*i -: 32]));
                v = (v <<< sc) >>> 16;
                if (v > 32767) v = 32767;
                if (v < -32768) v = -32768;
                r[31-16*i -: 16] = v[15:0];
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic issue(input logic [1:0] m, input logic [4:0] sc,
                         input logic [63:0] src, input logic [63:0] base);
        @(negedge clk);
        mode = m; scale = sc; pack_src = src; merge_base = base; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; in_valid = 1'b0; mode = 2'b00; scale = '0; pack_src = '0; merge_base = '0;
        repeat (2) @(negedge clk);
        check("R1 result after reset", result, 64'd0);
        check("R1 out_valid after reset", {63'd0, out_valid}, 64'd0);
        rst = 1'b0;
    endtask

    task automatic t_half_basic();
        issue(2'b00, 5'd0, 64'h0100_7FFF_8000_0080, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R2 out_valid one cycle later", {63'd0, out_valid}, 64'd1);
        check("R3 halfword pack scale 0", result, 64'h0000_0000_02FF_0001);
        issue(2'b00, 5'd4, 64'h0123_0800_FFF0_0010, '0);
        check("R3 halfword pack mixed clamp", result, model(2'b00, 5'd4, 64'h0123_0800_FFF0_0010, '0));
        issue(2'b00, 5'd15, 64'h0001_0000_FFFF_7FFF, '0);
        check("R8 halfword pack scale 15", result, 64'h0000_0000_FF00_00FF);
    endtask

    task automatic t_scale_msb();
        logic [63:0] src = 64'h0040_0011_0200_FF80;
        issue(2'b00, 5'b10010, src, '0);
        check("R4 scale bit 4 ignored", result, model(2'b00, 5'b00010, src, '0));
    endtask

    task automatic t_word_pack();
        issue(2'b01, 5'd0, 64'h0080_0000_7FFF_FFFF, 64'd0);
        check("R5 word pack scale 0", result, 64'h0000_0001_0000_00FF);
        issue(2'b01, 5'd3, 64'hFF00_0000_0012_3456, 64'd0);
        check("R5 word pack negative lane", result, model(2'b01, 5'd3, 64'hFF00_0000_0012_3456, 64'd0));
    endtask

    task automatic t_merge_chain();
        logic [63:0] acc = 64'h1122_3344_5566_7788;
        logic [63:0] exp;
        for (int k = 0; k < 3; k++) begin
            logic [63:0] src = {32'h0010_0000 * (k + 1), 32'h0020_0000 + 32'h0100_0000 * k};
            exp = model(2'b01, 5'd4, src, acc);
            issue(2'b01, 5'd4, src, acc);
            check("R6 merge into shifted base", result, exp);
            acc = result;
        end
    endtask

    task automatic t_fix();
        issue(2'b10, 5'd0, 64'h0001_8000_FFFF_0000, '0);
        check("R7 fixed pack scale 0", result, 64'h0000_0000_0001_FFFF);
        issue(2'b10, 5'd8, 64'h0100_0000_FF00_0000, '0);
        check("R7 fixed pack saturate both ends", result, 64'h0000_0000_7FFF_8000);
        issue(2'b10, 5'd31, 64'h0000_0001_FFFF_FFFF, '0);
        check("R8 fixed pack scale 31", result, 64'h0000_0000_7FFF_8000);
        issue(2'b01, 5'd31, 64'h0000_0001_FFFF_FFFF, 64'h0);
        check("R8 word pack scale 31", result, 64'h0000_00FF_0000_0000);
    endtask

    task automatic t_reserved_and_hold();
        logic [63:0] held;
        issue(2'b11, 5'd1, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R9 reserved mode zero", result, 64'd0);
        issue(2'b00, 5'd1, 64'h0100_0200_0300_0400, '0);
        held = result;
        @(negedge clk);
        mode = 2'b10; scale = 5'd20; pack_src = 64'h7FFF_FFFF_7FFF_FFFF;
        repeat (3) @(negedge clk);
        check("R2 result held while idle", result, held);
        check("R2 out_valid low while idle", {63'd0, out_valid}, 64'd0);
    endtask

    initial begin
        t_reset();
        t_half_basic();
        t_scale_msb();
        t_word_pack();
        t_merge_chain();
        t_fix();
        t_reserved_and_hold();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule